// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder, 16 Bits

This block is a purely combinational 16-bit adder with a carry input. It adds two operands and a carry input without passing a carry bit by bit. Every bit position first forms a generate term (both operand bits set) and a propagate term (either operand bit set). The sixteen bits are split into four slices of four bits each. Each slice turns its four generate/propagate pairs into one slice-level generate and one slice-level propagate.

A second-level lookahead unit takes the four slice pairs and the carry input. It produces the carry into every slice as a fully expanded sum of products. Each slice then uses the same expanded form to build its internal carries and XORs them with the operand bits to form its sum bits. The carry out of the top slice is the adder's carry-out.

The block also drives the whole-word propagate and generate. A third lookahead level can therefore combine several of these adders into a wider one without any carry rippling between them.

Top module: `cla16_two_level`

## Requirements
- R1: `{c_out, sum}` equals the 17-bit value of `a + b + c_in` for every input combination.
- R2: A bit position generates a carry when both operand bits are 1, and propagates a carry when at least one operand bit is 1. The exported block terms are built only from these per-bit terms.
- R3: `blk_prop` is 1 exactly when every one of the 16 bit positions propagates, that is when `(a | b) == 16'hFFFF`.
- R4: `blk_gen` equals the carry-out that the adder would produce with `c_in = 0`. It does not depend on `c_in`.
- R5: `c_out` equals `blk_gen | (blk_prop & c_in)`.
- R6: With a full propagate chain (`a = 16'hFFFF`, `b = 16'h0000`), `c_in = 1` gives `sum = 16'h0000` and `c_out = 1`, while `c_in = 0` gives `sum = 16'hFFFF` and `c_out = 0`.
- R7: A carry raised in any 4-bit slice (bits 3:0, 7:4, 11:8, 15:12) reaches the next slice. For example, `16'h000F + 16'h0001` gives `16'h0010`, `16'h0FFF + 16'h0001` gives `16'h1000`, and `16'h00FF + 16'h0000` with `c_in = 1` gives `16'h0100`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| c_out | output | 1 | Carry out of bit 15 |
| blk_prop | output | 1 | Whole-word propagate, for a third lookahead level |
| blk_gen | output | 1 | Whole-word generate, for a third lookahead level |

## Verification
The embedded checks are immediate assertions evaluated after the combinational logic settles. They assume that every input is a known 0 or 1, since an unknown bit would make the arithmetic comparisons meaningless. The bench meets this by driving fully defined values only: all stimulus comes from `$urandom` with a fixed seed or from directed constants, and inputs change away from the sampling point. Directed vectors cover full propagate chains, slice-boundary carries and the all-ones generate case. Random vectors cover the general sum.

// File: rtl/cla16_pkg.sv
// Package cla16_pkg
// Shared sizing for the two-level lookahead adder.
// Assumes the word is an exact number of slices.
package cla16_pkg;
    localparam int GRP_BITS  = 4;                     // bits per first-level slice
    localparam int GRP_COUNT = 4;                     // slices under the second level
    localparam int WORD_BITS = GRP_BITS * GRP_COUNT;  // total operand width
endpackage

// File: rtl/cla_pg_cell.sv
// Module cla_pg_cell
// Forms per-bit generate (AND) and propagate (OR) terms for a vector.
// Assumes known-valued operand bits.
module cla_pg_cell #(
    parameter int N = 4
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    output logic [N-1:0] gen,
    output logic [N-1:0] prop
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            // one bit's carry terms
            assign gen[i]  = op_a[i] & op_b[i];
            assign prop[i] = op_a[i] | op_b[i];
        end
    endgenerate

    // A generating bit always also propagates.
    always_comb begin
        for (int k = 0; k < N; k++) begin
            AST_GEN_IMPLIES_PROP: assert (!gen[k] || prop[k]) else $error("gen without prop");  // R2
        end
    end
endmodule

// File: rtl/cla_lookahead_unit.sv
// Module cla_lookahead_unit
// Expanded sum-of-products lookahead over N generate/propagate pairs.
// Produces every carry (carry[0] is the input carry) and the block P/G.
// Used both inside a slice (bit level) and across slices (second level).
// Assumes N stays small (the product terms grow as N squared).
module cla_lookahead_unit #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    input  logic         cin,
    output logic [N:0]   carry,
    output logic         prop_all,
    output logic         gen_all
);
    // block propagate: every position passes a carry
    always_comb begin
        prop_all = 1'b1;
        for (int m = 0; m < N; m++) prop_all = prop_all & prop[m];
    end

    // block generate: OR of each generate masked by all propagates above it
    always_comb begin
        logic term;
        gen_all = 1'b0;
        for (int j = 0; j < N; j++) begin
            term = gen[j];
            for (int m = j + 1; m < N; m++) term = term & prop[m];
            gen_all = gen_all | term;
        end
    end

    // every carry as a flat sum of products, none derived from another
    always_comb begin
        logic term;
        logic acc;
        carry    = '0;
        carry[0] = cin;
        for (int k = 1; k <= N; k++) begin
            acc = cin;
            for (int m = 0; m < k; m++) acc = acc & prop[m];
            for (int j = 0; j < k; j++) begin
                term = gen[j];
                for (int m = j + 1; m < k; m++) term = term & prop[m];
                acc = acc | term;
            end
            carry[k] = acc;
        end
    end

    // The top carry agrees with the block terms.
    always_comb begin
        AST_TOP_CARRY_PG: assert (carry[N] == (gen_all | (prop_all & cin))) else $error("top carry mismatch");  // R5
        AST_GEN_FORCES_CARRY: assert (!gen_all || carry[N]) else $error("generate without carry");  // R4
    end
endmodule

// File: rtl/cla_group.sv
// Module cla_group
// One first-level slice: bit P/G, slice P/G, internal carries and sums.
// Assumes its carry input arrives from the second-level unit.
module cla_group #(
    parameter int N = 4
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout,
    output logic         grp_prop,
    output logic         grp_gen
);
    logic [N-1:0] bit_gen;
    logic [N-1:0] bit_prop;
    logic [N:0]   carries;

    cla_pg_cell #(.N(N)) u_pg (
        .op_a (op_a),
        .op_b (op_b),
        .gen  (bit_gen),
        .prop (bit_prop)
    );

    cla_lookahead_unit #(.N(N)) u_la (
        .gen      (bit_gen),
        .prop     (bit_prop),
        .cin      (cin),
        .carry    (carries),
        .prop_all (grp_prop),
        .gen_all  (grp_gen)
    );

    // sum bits from operands and lookahead carries
    assign sum  = op_a ^ op_b ^ carries[N-1:0];
    assign cout = carries[N];

    // The slice result matches plain arithmetic.
    always_comb begin
        AST_GROUP_SUM: assert ({cout, sum} == ({1'b0, op_a} + {1'b0, op_b} + {{N{1'b0}}, cin})) else $error("slice sum");  // R1
    end
endmodule

// File: rtl/cla16_two_level.sv
// Module cla16_two_level
// Top: four 4-bit lookahead slices under a second-level lookahead unit.
// Exports the whole-word P/G for cascading. Purely combinational.
// Assumes known-valued inputs.
module cla16_two_level
    import cla16_pkg::*;
(
    input  logic [15:0] a,
    input  logic [15:0] b,
    input  logic        c_in,
    output logic [15:0] sum,
    output logic        c_out,
    output logic        blk_prop,
    output logic        blk_gen
);
    logic [GRP_COUNT-1:0] g_prop;
    logic [GRP_COUNT-1:0] g_gen;
    logic [GRP_COUNT-1:0] g_cout;
    logic [GRP_COUNT:0]   g_carry;

    genvar s;
    generate
        for (s = 0; s < GRP_COUNT; s++) begin : g_slice
            cla_group #(.N(GRP_BITS)) u_grp (
                .op_a     (a[s*GRP_BITS +: GRP_BITS]),
                .op_b     (b[s*GRP_BITS +: GRP_BITS]),
                .cin      (g_carry[s]),
                .sum      (sum[s*GRP_BITS +: GRP_BITS]),
                .cout     (g_cout[s]),
                .grp_prop (g_prop[s]),
                .grp_gen  (g_gen[s])
            );
        end
    endgenerate

    cla_lookahead_unit #(.N(GRP_COUNT)) u_level2 (
        .gen      (g_gen),
        .prop     (g_prop),
        .cin      (c_in),
        .carry    (g_carry),
        .prop_all (blk_prop),
        .gen_all  (blk_gen)
    );

    // carry-out is the second level's top carry
    assign c_out = g_carry[GRP_COUNT];

    // Slice-internal carry-outs agree with second-level carries; word sum is exact.
    always_comb begin
        for (int k = 0; k < GRP_COUNT; k++) begin
            AST_SLICE_HANDOFF: assert (g_cout[k] == g_carry[k+1]) else $error("slice handoff");  // R7
        end
        AST_WORD_SUM: assert ({c_out, sum} == ({1'b0, a} + {1'b0, b} + {16'd0, c_in})) else $error("word sum");  // R1
        AST_BLK_PROP: assert (blk_prop == (&(a | b))) else $error("block propagate");  // R3
    end
endmodule

// File: tb/cla16_two_level_bench.sv
module cla16_two_level_bench;
    logic        clk;
    logic [15:0] a;
    logic [15:0] b;
    logic        c_in;
    logic [15:0] sum;
    logic        c_out;
    logic        blk_prop;
    logic        blk_gen;
    int          total;
    int          bad;
    logic        done;

    cla16_two_level u_cla16_two_level (
        .a(a), .b(b), .c_in(c_in),
        .sum(sum), .c_out(c_out), .blk_prop(blk_prop), .blk_gen(blk_gen)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    function automatic logic [16:0] ref_add(logic [15:0] x, logic [15:0] y, logic ci);
        return {1'b0, x} + {1'b0, y} + {16'd0, ci};
    endfunction

    function automatic logic ref_prop(logic [15:0] x, logic [15:0] y);
        logic r = 1'b1;
        for (int i = 0; i < 16; i++) r = r & (x[i] | y[i]);
        return r;
    endfunction

    function automatic logic ref_gen(logic [15:0] x, logic [15:0] y);
        logic [16:0] t = {1'b0, x} + {1'b0, y};
        return t[16];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (a=%h b=%h c_in=%b)", req, act, exp, a, b, c_in);
        end
    endtask

    // drive at negedge, sample one ns later
    task automatic apply(logic [15:0] x, logic [15:0] y, logic ci);
        @(negedge clk);
        a = x; b = y; c_in = ci;
        #1;
    endtask

    task automatic check_all(string tag);
        logic [16:0] e;
        e = ref_add(a, b, c_in);
        chk({tag, " R1 sum"}, {15'd0, c_out, sum}, {15'd0, e});
        chk({tag, " R3 prop"}, {31'd0, blk_prop}, {31'd0, ref_prop(a, b)});
        chk({tag, " R2 R4 gen"}, {31'd0, blk_gen}, {31'd0, ref_gen(a, b)});
        chk({tag, " R5 cout"}, {31'd0, c_out}, {31'd0, ref_gen(a, b) | (ref_prop(a, b) & c_in)});
    endtask

    initial begin
        done = 1'b0;
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic        c0_out;
        total = 0; bad = 0;
        a = '0; b = '0; c_in = 1'b0;
        seed = $urandom(32'd350);
        apply(16'h0000, 16'h0000, 1'b0);
        chk("R1 zero", {15'd0, c_out, sum}, 32'd0);
        chk("R3 zero prop", {31'd0, blk_prop}, 32'd0);
        // R6 full propagate chain
        apply(16'hFFFF, 16'h0000, 1'b1);
        chk("R6 fp sum", {16'd0, sum}, 32'h0000);
        chk("R6 fp cout", {31'd0, c_out}, 32'd1);
        chk("R3 fp prop", {31'd0, blk_prop}, 32'd1);
        chk("R4 fp gen", {31'd0, blk_gen}, 32'd0);
        apply(16'hFFFF, 16'h0000, 1'b0);
        chk("R6 fp0 sum", {16'd0, sum}, 32'hFFFF);
        chk("R6 fp0 cout", {31'd0, c_out}, 32'd0);
        apply(16'h0000, 16'hFFFF, 1'b1);
        chk("R6 fp swap", {15'd0, c_out, sum}, 32'h10000);
        apply(16'hAAAA, 16'h5555, 1'b1);
        chk("R6 alt chain", {15'd0, c_out, sum}, 32'h10000);
        // R7 slice boundaries
        apply(16'h000F, 16'h0001, 1'b0);
        chk("R7 s0->s1", {15'd0, c_out, sum}, 32'h0010);
        apply(16'h00FF, 16'h0000, 1'b1);
        chk("R7 s1->s2", {15'd0, c_out, sum}, 32'h0100);
        apply(16'h0FFF, 16'h0001, 1'b0);
        chk("R7 s2->s3", {15'd0, c_out, sum}, 32'h1000);
        apply(16'h0F00, 16'h0100, 1'b0);
        chk("R7 mid", {15'd0, c_out, sum}, 32'h1000);
        // R2 R4 all-generate, and R4 independence of c_in
        apply(16'hFFFF, 16'hFFFF, 1'b0);
        chk("R2 all gen", {31'd0, blk_gen}, 32'd1);
        chk("R1 all gen sum", {15'd0, c_out, sum}, 32'h1FFFE);
        apply(16'h8000, 16'h8000, 1'b1);
        chk("R4 top gen", {31'd0, blk_gen}, 32'd1);
        chk("R1 top gen sum", {15'd0, c_out, sum}, 32'h10001);
        for (int n = 0; n < 2000; n++) begin
            logic [15:0] x;
            logic [15:0] y;
            x = 16'($urandom);
            y = 16'($urandom);
            case (n % 4)
                1: y = ~x;
                2: y = ~x ^ (16'd1 << (n % 16));
                default: ;
            endcase
            apply(x, y, 1'b0);
            c0_out = c_out;
            check_all("rand0");
            apply(x, y, 1'b1);
            check_all("rand1");
            chk("R4 gen is c_in=0 carry", {31'd0, blk_gen}, {31'd0, c0_out});
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule